// File: doc/BRIEF.md
# Multicycle Shared-Memory Processor Datapath

This block is the 32-bit datapath of a processor that takes several clock cycles per instruction. It has one memory port, and that port is used in turn for two jobs: fetching instructions and reading or writing data. Values that one step produces and a later step consumes are kept in internal holding registers. These are the instruction register, the memory data register, two operand registers loaded from the register file, and an ALU result register. The datapath also contains the program counter, a 32-entry register file, an immediate sign extender, a word-offset shifter and an ALU.

The block makes no sequencing decisions. An external controller drives every write enable, every multiplexer select and the 3-bit ALU operation code, one vector per cycle. The controller gets back the instruction's opcode field and the ALU's zero flag. The memory sits outside the block. It receives a byte address and write data, and it returns read data combinationally.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, the instruction register and all holding registers to zero.
- R2: `mem_addr` carries the program counter when `addr_sel` is 0 and the ALU result register when `addr_sel` is 1. `mem_wdata` always carries the B operand register.
- R3: The instruction register loads `mem_rdata` on a clock edge only when `ir_we` is 1, and holds otherwise. `opcode` is instruction bits [31:26]. The other fields are source register [25:21], target register [20:16], destination register [15:11] and immediate [15:0].
- R4: The first ALU input is the program counter when `a_sel` is 0 and register A when `a_sel` is 1.
- R5: The second ALU input is selected by `b_sel`: 0 gives register B, 1 gives the constant 4, 2 gives the sign-extended immediate, and 3 gives the sign-extended immediate shifted left by two.
- R6: `alu_op` encodings are 010 add, 110 subtract, 000 bitwise AND, 001 bitwise OR, and 111 signed set-less-than (result 1 or 0). Every other code gives a zero result. `zero` is 1 exactly when the live ALU result is all zeros.
- R7: Registers A and B load the register-file words addressed by the source and target fields, the ALU result register loads the live ALU result, and the memory data register loads `mem_rdata`. All four load on every clock edge with no enable.
- R8: The program counter loads only when `pc_we` is 1. It takes the live ALU result when `pc_sel` is 0 and the ALU result register when `pc_sel` is 1.
- R9: When `rf_we` is 1, the register file writes the target field's register if `dst_sel` is 0 or the destination field's register if `dst_sel` is 1. The data written is the ALU result register if `wb_sel` is 0 or the memory data register if `wb_sel` is 1.
- R10: Register 0 always reads as zero, and writes addressed to it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_we | input | 1 | Program counter load enable |
| pc_sel | input | 1 | Program counter source: 0 live ALU, 1 ALU result register |
| ir_we | input | 1 | Instruction register load enable |
| addr_sel | input | 1 | Memory address source: 0 PC, 1 ALU result register |
| a_sel | input | 1 | First ALU input: 0 PC, 1 register A |
| b_sel | input | 2 | Second ALU input select |
| alu_op | input | 3 | ALU operation code |
| rf_we | input | 1 | Register file write enable |
| dst_sel | input | 1 | Write address: 0 target field, 1 destination field |
| wb_sel | input | 1 | Write data: 0 ALU result register, 1 memory data register |
| mem_rdata | input | 32 | Read data from the memory |
| mem_addr | output | 32 | Byte address to the memory |
| mem_wdata | output | 32 | Write data to the memory (register B) |
| opcode | output | 6 | Instruction register bits [31:26] |
| zero | output | 1 | Live ALU result equals zero |

## Verification
The bench runs short control sequences, one per instruction, against a modelled memory holding a small program. There are three loads: two with a zero base and one with a negative offset from a loaded base. These separate the plain immediate from the shifted immediate, and separate sign extension from zero extension. A register add, an equal subtract, a store and two branches follow. The branches differ: one has a taken forward offset and one an untaken backward offset, so they tell the live and registered PC sources apart, and show that the PC holds when its enable is low. A write aimed at register 0 is followed by a read of register 0. Each ALU code is then applied to ordered and reversed operand pairs, so that set-less-than, subtraction wraparound and the unused codes all show distinct results.

// File: rtl/mc_pkg.sv
package mc_pkg;
   localparam int INSN_W = 32;
   localparam int OPC_W  = 6;
   localparam int RIDX_W = 5;
   localparam int IMM_W  = 16;

   localparam int OPC_LSB = 26;
   localparam int RS_LSB  = 21;
   localparam int RT_LSB  = 16;
   localparam int RD_LSB  = 11;

   typedef enum logic [2:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_SUB = 3'b110,
      ALU_SLT = 3'b111
   } alu_op_e;

   typedef enum logic [1:0] {
      OPB_REG   = 2'd0,
      OPB_FOUR  = 2'd1,
      OPB_IMM   = 2'd2,
      OPB_IMMSH = 2'd3
   } opb_sel_e;
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int W    = 32,
   parameter int NREG = 32,
   localparam int AW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] ra,
   input  logic [AW-1:0] rb,
   output logic [W-1:0]  da,
   output logic [W-1:0]  db
);
   if (NREG < 2) begin : g_chk_depth
      $error("mc_regfile: NREG must be at least 2");
   end
   if (NREG != (1 << AW)) begin : g_chk_pow2
      $error("mc_regfile: NREG must be a power of two");
   end

   // Entry 0 has no storage: it is a constant zero (R10).
   logic [W-1:0] regs [1:NREG-1];

   for (genvar g = 1; g < NREG; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (we && (waddr == AW'(g))) regs[g] <= wdata;
      end
   end

   always_comb begin
      da = '0;
      db = '0;
      for (int i = 1; i < NREG; i++) begin
         if (ra == AW'(i)) da = regs[i];
         if (rb == AW'(i)) db = regs[i];
      end
   end

   // R9: a write to a nonzero entry is visible on the next cycle.
   a_r9_write_lands: assert property (@(posedge clk)
      (we && waddr != '0 && ra == waddr) |=> (ra != $past(waddr)) || (da == $past(wdata)));
endmodule

// File: rtl/mc_operand.sv
module mc_operand
   import mc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0]     pc,
   input  logic [W-1:0]     a_q,
   input  logic [W-1:0]     b_q,
   input  logic [IMM_W-1:0] imm,
   input  logic             a_sel,
   input  logic [1:0]       b_sel,
   output logic [W-1:0]     opa,
   output logic [W-1:0]     opb
);
   localparam int EXT_W = W - IMM_W;

   logic [W-1:0] imm_sx;
   logic [W-1:0] imm_sh;

   assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
   assign imm_sh = {imm_sx[W-3:0], 2'b00};

   assign opa = a_sel ? a_q : pc;

   always_comb begin
      unique case (opb_sel_e'(b_sel))
         OPB_REG:   opb = b_q;
         OPB_FOUR:  opb = W'(4);
         OPB_IMM:   opb = imm_sx;
         OPB_IMMSH: opb = imm_sh;
         default:   opb = b_q;
      endcase
   end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
   import mc_pkg::*;
#(
   parameter int W      = 32,
   parameter bit SLT_EN = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [2:0]   op,
   output logic [W-1:0] y,
   output logic         zero
);
   logic [W-1:0] slt_val;

   if (SLT_EN) begin : g_slt
      assign slt_val = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
   end else begin : g_no_slt
      assign slt_val = '0;
   end

   always_comb begin
      case (op)
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_SLT: y = slt_val;
         default: y = '0;
      endcase
   end

   assign zero = (y == '0);
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
   import mc_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int NREG   = 32,
   parameter bit SLT_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            pc_we,
   input  logic            pc_sel,
   input  logic            ir_we,
   input  logic            addr_sel,
   input  logic            a_sel,
   input  logic [1:0]      b_sel,
   input  logic [2:0]      alu_op,
   input  logic            rf_we,
   input  logic            dst_sel,
   input  logic            wb_sel,
   input  logic [XLEN-1:0] mem_rdata,
   output logic [XLEN-1:0] mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   output logic [OPC_W-1:0] opcode,
   output logic            zero
);
   localparam int AW = $clog2(NREG);

   if (XLEN != INSN_W) begin : g_chk_xlen
      $error("mc_datapath: XLEN must equal the instruction width");
   end
   if (AW != RIDX_W) begin : g_chk_nreg
      $error("mc_datapath: NREG must match the register field width");
   end

   logic [XLEN-1:0] pc, ir, mdr, a_q, b_q, alu_q;
   logic [XLEN-1:0] rf_da, rf_db, opa, opb, alu_y, pc_next, wb_data;
   logic [AW-1:0]   f_rs, f_rt, f_rd, waddr;
   logic [IMM_W-1:0] f_imm;

   assign opcode = ir[OPC_LSB +: OPC_W];
   assign f_rs   = ir[RS_LSB +: AW];
   assign f_rt   = ir[RT_LSB +: AW];
   assign f_rd   = ir[RD_LSB +: AW];
   assign f_imm  = ir[IMM_W-1:0];

   assign waddr   = dst_sel ? f_rd : f_rt;
   assign wb_data = wb_sel ? mdr : alu_q;

   mc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
      .clk   (clk),
      .we    (rf_we),
      .waddr (waddr),
      .wdata (wb_data),
      .ra    (f_rs),
      .rb    (f_rt),
      .da    (rf_da),
      .db    (rf_db)
   );

   mc_operand #(.W(XLEN)) u_opnd (
      .pc    (pc),
      .a_q   (a_q),
      .b_q   (b_q),
      .imm   (f_imm),
      .a_sel (a_sel),
      .b_sel (b_sel),
      .opa   (opa),
      .opb   (opb)
   );

   mc_alu #(.W(XLEN), .SLT_EN(SLT_EN)) u_alu (
      .a    (opa),
      .b    (opb),
      .op   (alu_op),
      .y    (alu_y),
      .zero (zero)
   );

   assign pc_next   = pc_sel ? alu_q : alu_y;
   assign mem_addr  = addr_sel ? alu_q : pc;
   assign mem_wdata = b_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc    <= '0;
         ir    <= '0;
         mdr   <= '0;
         a_q   <= '0;
         b_q   <= '0;
         alu_q <= '0;
      end else begin
         if (pc_we) pc <= pc_next;
         if (ir_we) ir <= mem_rdata;
         mdr   <= mem_rdata;
         a_q   <= rf_da;
         b_q   <= rf_db;
         alu_q <= alu_y;
      end
   end

   // R1: reset leaves the program counter at zero.
   a_r1_reset_pc: assert property (@(posedge clk) rst |=> (pc == '0));

   // R8: the program counter is frozen while its enable is low.
   a_r8_pc_hold: assert property (@(posedge clk) disable iff (rst)
      !pc_we |=> $stable(pc));

   // R8: on load, the program counter takes the selected source.
   a_r8_pc_load: assert property (@(posedge clk) disable iff (rst)
      (pc_we && !pc_sel) |=> (pc == $past(alu_y)));

   // R3: the instruction register holds without its enable.
   a_r3_ir_hold: assert property (@(posedge clk) disable iff (rst)
      !ir_we |=> $stable(ir));

   // R7: the memory data register follows the read data one cycle late.
   a_r7_mdr_follow: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (mdr == $past(mem_rdata)));

   // R6: subtracting equal operands raises the zero flag.
   a_r6_sub_eq_zero: assert property (@(posedge clk) disable iff (rst)
      (alu_op == ALU_SUB && opa == opb) |-> zero);
endmodule

// File: tb/tb_mc_datapath.sv
module tb_mc_datapath;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        pc_we, pc_sel, ir_we, addr_sel, a_sel, rf_we, dst_sel, wb_sel;
   logic [1:0]  b_sel;
   logic [2:0]  alu_op;
   logic [31:0] mem_rdata, mem_addr, mem_wdata;
   logic [5:0]  opcode;
   logic        zero;
   logic        mem_wr;
   logic [31:0] mem [64];
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   localparam logic [2:0] OP_AND = 3'b000, OP_OR = 3'b001, OP_ADD = 3'b010,
                          OP_SUB = 3'b110, OP_SLT = 3'b111, OP_BAD = 3'b011;

   always #5 clk = ~clk;

   mc_datapath dut (
      .clk(clk), .rst(rst), .pc_we(pc_we), .pc_sel(pc_sel), .ir_we(ir_we),
      .addr_sel(addr_sel), .a_sel(a_sel), .b_sel(b_sel), .alu_op(alu_op),
      .rf_we(rf_we), .dst_sel(dst_sel), .wb_sel(wb_sel), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .opcode(opcode), .zero(zero)
   );

   assign mem_rdata = mem[mem_addr[7:2]];
   always @(posedge clk) if (mem_wr) mem[mem_addr[7:2]] <= mem_wdata;

   function automatic logic [31:0] ei(int op, int rs, int rt, int imm);
      return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
   endfunction
   function automatic logic [31:0] er(int rs, int rt, int rd, int fn);
      return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
   endfunction

   task automatic ck(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      pc_we = 0; pc_sel = 0; ir_we = 0; addr_sel = 0; a_sel = 0; b_sel = 0;
      alu_op = OP_ADD; rf_we = 0; dst_sel = 0; wb_sel = 0; mem_wr = 0;
   endtask

   task automatic step();
      @(posedge clk); #1;
      idle();
   endtask

   task automatic peek_alu(output logic [31:0] v);
      addr_sel = 1; #1; v = mem_addr; addr_sel = 0; #1;
   endtask

   task automatic fetch(logic [31:0] pc_after, logic [5:0] opc);
      ir_we = 1; b_sel = 1; alu_op = OP_ADD; pc_we = 1; step();
      ck("R8 pc increment", mem_addr, pc_after);
      ck("R3 opcode", {26'd0, opc}, {26'd0, opcode});
   endtask

   task automatic decode(); b_sel = 3; step(); endtask
   task automatic eff();    a_sel = 1; b_sel = 2; step(); endtask

   task automatic exec(logic [2:0] op, output logic z);
      a_sel = 1; b_sel = 0; alu_op = op; #1; z = zero; step();
   endtask

   task automatic load_insn(logic [31:0] pc_after, logic [31:0] dec_exp, logic [31:0] ea_exp);
      logic [31:0] v;
      fetch(pc_after, 6'd35);
      decode(); peek_alu(v); ck("R5 shifted immediate", v, dec_exp);
      eff();    peek_alu(v); ck("R5 sign-extended immediate", v, ea_exp);
      addr_sel = 1; step();
      rf_we = 1; dst_sel = 0; wb_sel = 1; step();
   endtask

   task automatic t_reset();
      ck("R1 pc after reset", mem_addr, 32'd0);
      ck("R1 ir after reset", {26'd0, opcode}, 32'd0);
   endtask

   task automatic t_loads();
      load_insn(32'd4,  32'd516,       32'd128);
      load_insn(32'd8,  32'd536,       32'd132);
      load_insn(32'd12, 32'hFFFF_FFDC, 32'h0000_0084);
   endtask

   task automatic t_rtype();
      logic [31:0] v; logic z;
      fetch(32'd16, 6'd0); decode();
      ck("R7 B loaded (R9 lw writeback)", mem_wdata, 32'h90);
      exec(OP_ADD, z); peek_alu(v); ck("R4 add on register A", v, 32'h1234_5708);
      rf_we = 1; dst_sel = 1; step();
      fetch(32'd20, 6'd0); decode();
      exec(OP_SUB, z); ck("R6 zero on equal subtract", {31'd0, z}, 32'd1);
      rf_we = 1; dst_sel = 1; step();
   endtask

   task automatic t_store();
      logic [31:0] v;
      fetch(32'd24, 6'd43); decode();
      ck("R3 ir holds without enable", {26'd0, opcode}, 32'd43);
      ck("R9 rd writeback seen on B", mem_wdata, 32'h1234_5708);
      eff(); peek_alu(v); ck("R5 positive immediate", v, 32'd136);
      addr_sel = 1; mem_wr = 1; #1;
      ck("R2 address from ALU register", mem_addr, 32'd136);
      step();
      ck("R2 store data from B", mem[34], 32'h1234_5708);
   endtask

   task automatic t_branches();
      logic [31:0] v; logic z;
      fetch(32'd28, 6'd4); decode(); peek_alu(v);
      ck("R5 forward branch target", v, 32'd36);
      a_sel = 1; b_sel = 0; alu_op = OP_SUB; pc_we = 1; pc_sel = 1; #1; z = zero; step();
      ck("R6 taken branch zero", {31'd0, z}, 32'd1);
      ck("R8 pc from ALU register", mem_addr, 32'd36);
      fetch(32'd40, 6'd4); decode(); peek_alu(v);
      ck("R5 backward branch target", v, 32'd28);
      exec(OP_SUB, z);
      ck("R6 untaken branch zero", {31'd0, z}, 32'd0);
      ck("R8 pc holds with enable low", mem_addr, 32'd40);
   endtask

   task automatic t_reg0();
      logic [31:0] v; logic z;
      fetch(32'd44, 6'd0); decode();
      exec(OP_OR, z); peek_alu(v); ck("R6 or", v, 32'h1234_56F8);
      rf_we = 1; dst_sel = 1; step();
      fetch(32'd48, 6'd0); decode();
      ck("R10 register 0 reads zero after write", mem_wdata, 32'd0);
   endtask

   task automatic t_alu_ops();
      logic [31:0] v; logic z;
      exec(OP_AND, z); peek_alu(v); ck("R6 and", v, 32'd0);
      ck("R6 zero on and", {31'd0, z}, 32'd1);
      exec(OP_OR,  z); peek_alu(v); ck("R6 or with zero", v, 32'h1234_5678);
      exec(OP_SLT, z); peek_alu(v); ck("R6 slt false", v, 32'd0);
      exec(OP_BAD, z); peek_alu(v); ck("R6 unused code", v, 32'd0);
      fetch(32'd52, 6'd0); decode();
      exec(OP_SLT, z); peek_alu(v); ck("R6 slt true", v, 32'd1);
      exec(OP_SUB, z); peek_alu(v); ck("R6 sub wraps", v, 32'hEDCB_A988);
      b_sel = 1; alu_op = OP_ADD; step(); peek_alu(v);
      ck("R4 live pc plus four", v, 32'd56);
      ck("R7 ALU register reloads", v, 32'd56);
   endtask

   initial begin
      idle();
      for (int i = 0; i < 64; i++) mem[i] = 32'd0;
      mem[0]  = ei(35, 0, 1, 128);
      mem[1]  = ei(35, 0, 2, 132);
      mem[2]  = ei(35, 2, 5, 16'hFFF4);
      mem[3]  = er(1, 2, 3, 32);
      mem[4]  = er(5, 2, 4, 34);
      mem[5]  = ei(43, 0, 3, 136);
      mem[6]  = ei(4, 4, 0, 2);
      mem[9]  = ei(4, 1, 0, 16'hFFFD);
      mem[10] = er(1, 2, 0, 37);
      mem[11] = er(1, 0, 6, 36);
      mem[12] = er(4, 1, 7, 42);
      mem[32] = 32'h1234_5678;
      mem[33] = 32'h0000_0090;
      repeat (3) @(posedge clk);
      #1 rst = 0;
      t_reset();
      t_loads();
      t_rtype();
      t_store();
      t_branches();
      t_reg0();
      t_alu_ops();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule